// File: doc/BRIEF.md
# GF(2^32) Additive-FFT Butterfly Unit

This block performs the butterfly step of an additive FFT over the binary field GF(2^32). The field is built on the modulus x^32 + x^15 + x^9 + x^7 + x^3 + 1. Each accepted beat carries a group of four lanes. Every lane holds a pair of field elements (u, w), and all four lanes share one twiddle factor lambda. For each live lane the unit first forms u' = u + lambda·w. It then forms w' = w + u', using the u' it has just computed. In this field, addition is bitwise XOR and multiplication is a carry-less product reduced modulo the polynomial.

Every lane has its own 32x32 carry-less multiplier and a two-pass fold reducer. The pipeline has two stages. Stage one forms the 64-bit product and registers it. Stage two reduces the product, applies the two XORs and registers the outputs. Input and output use a valid/ready handshake, so a stream of groups can pass at one group per cycle. A final group with fewer than four elements marks its live lanes with an enable mask. A lane that is switched off passes its u and w through unchanged and reports itself not valid.

Top module: `gfbf_butterfly`

## Requirements
- R1: For each enabled lane, out_u equals in_u XOR (in_lambda · in_w) in GF(2^32), where the modulus is x^32 + x^15 + x^9 + x^7 + x^3 + 1 (low-word taps 32'h0000_8289).
- R2: For each enabled lane, out_w equals in_w XOR out_u, using the updated u of the same lane.
- R3: The four lanes share in_lambda and are computed independently. Lane k occupies bits [32k+31:32k] of in_u, in_w, out_u and out_w.
- R4: When bit k of in_lane_en is 0, lane k outputs its in_u and in_w unchanged and out_lane_vld[k] is 0. When bit k is 1, out_lane_vld[k] is 1 and the lane's result matches the full-group result. out_lane_vld is all zero whenever out_valid is 0.
- R5: A group accepted at a clock edge, with out_ready held high, appears at out_valid after the second following edge and not after the first.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0 and all outputs hold their values.
- R7: While rst is high and after it is released with no input, out_valid is 0, out_lane_vld is 0 and in_ready is 1.
- R8: Each accepted group yields exactly one output group, and groups leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Unit can accept a group this cycle |
| in_lane_en | input | 4 | Live-lane mask for the group |
| in_lambda | input | 32 | Shared twiddle factor |
| in_u | input | 128 | Four u elements, lane k at [32k+31:32k] |
| in_w | input | 128 | Four w elements, lane k at [32k+31:32k] |
| out_valid | output | 1 | Output group present |
| out_ready | input | 1 | Downstream accepts the output group |
| out_lane_vld | output | 4 | Per-lane result valid |
| out_u | output | 128 | Updated u elements |
| out_w | output | 128 | Updated w elements |

## Verification
The assertions check several things on every cycle. The outputs stay frozen and in_ready stays low while downstream stalls. Per-lane valid bits never appear without a group. A disabled lane's stage-one operands reach the output untouched. For an enabled lane, out_u XOR out_w restores the w that entered stage two. The fold reducer returns the low word unchanged when the product has no high half. The field arithmetic itself can only be shown by the bench's scenarios. These compare every lane against a bit-serial multiply-and-reduce model for zero and unit twiddles, all-ones operands, distinct per-lane data, partial masks and random streams. The scenarios also cover the two-edge latency and the ordering of groups under irregular back-pressure.

// File: rtl/gfbf_pkg.sv
package gfbf_pkg;
  // element width of the field
  localparam int unsigned ELEM_W   = 32;
  // low part of the modulus: bits 0,3,7,9,15 (bit ELEM_W implied)
  localparam logic [ELEM_W-1:0] MOD_TAPS = 32'h0000_8289;
  // lanes processed per group
  localparam int unsigned LANE_CNT = 4;
endpackage

// File: rtl/gfbf_clmul.sv
module gfbf_clmul #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);
  localparam int unsigned PW = 2 * W;

  // sum of shifted partial products, XOR in place of add
  always_comb begin
    prod = '0;
    for (int i = 0; i < W; i++) begin
      if (op_b[i]) prod = prod ^ ({{W{1'b0}}, op_a} << i);
    end
  end

  // top bit of a W x W carry-less product is always clear
  always_comb begin
    if (!$isunknown({op_a, op_b}))
      clmul_top_zero_chk: assert (prod[PW-1] == 1'b0);
  end
endmodule

// File: rtl/gfbf_fold.sv
module gfbf_fold #(
  parameter int unsigned      W    = 32,
  parameter logic [W-1:0]     TAPS = 32'h0000_8289
) (
  input  logic [2*W-1:0] prod,
  output logic [W-1:0]   rem
);
  logic [W-1:0] hi_part;
  logic [W-1:0] lo_part;
  logic [W-1:0] tmp;

  assign hi_part = prod[2*W-1:W];
  assign lo_part = prod[W-1:0];

  // first pass: fold the spill of the high half back into it
  always_comb begin
    tmp = hi_part;
    for (int t = 1; t < W; t++) begin
      if (TAPS[t]) tmp = tmp ^ (hi_part >> (W - t));
    end
  end

  // second pass: multiply the folded word by the tap pattern
  always_comb begin
    rem = lo_part;
    for (int t = 0; t < W; t++) begin
      if (TAPS[t]) rem = rem ^ (tmp << t);
    end
  end

  // R1
  always_comb begin
    if (!$isunknown(prod) && hi_part == '0)
      fold_passthru_chk: assert (rem == lo_part);
  end
endmodule

// File: rtl/gfbf_lane.sv
module gfbf_lane #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] TAPS = 32'h0000_8289
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         s1_vld,
  input  logic [W-1:0] lam,
  input  logic [W-1:0] u_in,
  input  logic [W-1:0] w_in,
  input  logic         en_in,
  output logic [W-1:0] u_out,
  output logic [W-1:0] w_out,
  output logic         vld_out
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] prod_c;
  logic [PW-1:0] prod_q;
  logic [W-1:0]  u_q, w_q;
  logic          en_q;
  logic [W-1:0]  red_c;
  logic [W-1:0]  u_new, w_new;

  gfbf_clmul #(.W(W)) u_mul (
    .op_a(lam),
    .op_b(w_in),
    .prod(prod_c)
  );

  // stage 1: product and operands
  always_ff @(posedge clk) begin
    if (adv) begin
      prod_q <= prod_c;
      u_q    <= u_in;
      w_q    <= w_in;
      en_q   <= en_in;
    end
  end

  gfbf_fold #(.W(W), .TAPS(TAPS)) u_fold (
    .prod(prod_q),
    .rem (red_c)
  );

  // stage 2: reduce, update u, then w from the new u
  always_comb begin
    if (en_q) begin
      u_new = u_q ^ red_c;
      w_new = w_q ^ u_new;
    end else begin
      u_new = u_q;
      w_new = w_q;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      u_out <= u_new;
      w_out <= w_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      vld_out <= 1'b0;
    else if (adv) vld_out <= s1_vld & en_q;
  end

  // R4
  lane_off_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && s1_vld && !en_q) |=> (u_out == $past(u_q) && w_out == $past(w_q) && !vld_out));

  // R2
  lane_w_from_u_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && s1_vld && en_q) |=> ((u_out ^ w_out) == $past(w_q)));
endmodule

// File: rtl/gfbf_butterfly.sv
module gfbf_butterfly
  import gfbf_pkg::*;
#(
  parameter int unsigned          LANES = LANE_CNT,
  parameter int unsigned          EW    = ELEM_W,
  parameter logic [ELEM_W-1:0]    TAPS  = MOD_TAPS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES-1:0]      in_lane_en,
  input  logic [EW-1:0]         in_lambda,
  input  logic [LANES*EW-1:0]   in_u,
  input  logic [LANES*EW-1:0]   in_w,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES-1:0]      out_lane_vld,
  output logic [LANES*EW-1:0]   out_u,
  output logic [LANES*EW-1:0]   out_w
);
  localparam int unsigned BUS_W = LANES * EW;

  logic adv;
  logic s1_vld_q;
  logic out_vld_q;

  // whole pipeline advances together; a held output stalls everything
  assign adv      = !out_vld_q || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld_q  <= 1'b0;
      out_vld_q <= 1'b0;
    end else if (adv) begin
      s1_vld_q  <= in_valid;
      out_vld_q <= s1_vld_q;
    end
  end

  assign out_valid = out_vld_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    gfbf_lane #(.W(EW), .TAPS(TAPS[EW-1:0])) u_lane (
      .clk    (clk),
      .rst    (rst),
      .adv    (adv),
      .s1_vld (s1_vld_q),
      .lam    (in_lambda),
      .u_in   (in_u[k*EW +: EW]),
      .w_in   (in_w[k*EW +: EW]),
      .en_in  (in_lane_en[k]),
      .u_out  (out_u[k*EW +: EW]),
      .w_out  (out_w[k*EW +: EW]),
      .vld_out(out_lane_vld[k])
    );
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_u) && $stable(out_w)
                                   && $stable(out_lane_vld)));

  // R6
  stall_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R4
  lane_vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_lane_vld == '0));

  // R8
  group_flow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && out_ready) |=> ##1 out_valid);

  logic [BUS_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: tb/tb_gfbf_butterfly.sv
module tb_gfbf_butterfly;
  localparam int L  = 4;
  localparam int W  = 32;
  localparam int BW = L * W;
  localparam logic [W-1:0] POLY_LO = 32'h0000_8289;

  logic          clk, rst;
  logic          in_valid, in_ready;
  logic [L-1:0]  in_lane_en;
  logic [W-1:0]  in_lambda;
  logic [BW-1:0] in_u, in_w;
  logic          out_valid, out_ready;
  logic [L-1:0]  out_lane_vld;
  logic [BW-1:0] out_u, out_w;

  gfbf_butterfly dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_lane_en(in_lane_en), .in_lambda(in_lambda),
    .in_u(in_u), .in_w(in_w),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_lane_vld(out_lane_vld), .out_u(out_u), .out_w(out_w)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [BW-1:0] q_u[$];
  logic [BW-1:0] q_w[$];
  logic [L-1:0]  q_v[$];
  string         q_tag[$];

  // bit-serial multiply with reduction after every shift
  function automatic logic [W-1:0] gmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    logic         c;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      c = r[W-1];
      r = r << 1;
      if (c) r = r ^ POLY_LO;
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one group at a negedge, wait for acceptance, queue expectation
  task automatic send(input string tag, input logic [W-1:0] lam,
                      input logic [BW-1:0] u, input logic [BW-1:0] w,
                      input logic [L-1:0] en);
    logic [BW-1:0] eu, ew;
    logic [W-1:0]  up;
    in_valid   = 1'b1;
    in_lambda  = lam;
    in_u       = u;
    in_w       = w;
    in_lane_en = en;
    while (!in_ready) @(negedge clk);
    for (int k = 0; k < L; k++) begin
      if (en[k]) begin
        up = u[k*W +: W] ^ gmul(lam, w[k*W +: W]);
        eu[k*W +: W] = up;
        ew[k*W +: W] = w[k*W +: W] ^ up;
      end else begin
        eu[k*W +: W] = u[k*W +: W];
        ew[k*W +: W] = w[k*W +: W];
      end
    end
    q_u.push_back(eu);
    q_w.push_back(ew);
    q_v.push_back(en);
    q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [BW-1:0] rnd_bus();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // ready generator, updated just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0] | lfsr[5];
      default: out_ready = 1'b0;
    endcase
  end

  // monitor / scoreboard
  logic          stall_prev = 1'b0;
  logic [BW-1:0] hold_u, hold_w;
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev) begin
        chk("R6 held u", out_u, hold_u);
        chk("R6 held w", out_w, hold_w);
      end
      if (out_valid && !out_ready) begin
        chk("R6 in_ready low", {127'b0, in_ready}, '0);
        stall_prev = 1'b1;
        hold_u = out_u;
        hold_w = out_w;
      end else begin
        stall_prev = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (q_u.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R8 unexpected group actual=%h expected=none", out_u);
        end else begin
          string t;
          t = q_tag.pop_front();
          chk({t, " R1 u"}, out_u, q_u.pop_front());
          chk({t, " R2 w"}, out_w, q_w.pop_front());
          chk({t, " R4 lane_vld"}, {124'b0, out_lane_vld}, {124'b0, q_v.pop_front()});
        end
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_lane_en = '0; in_lambda = '0;
    in_u = '0; in_w = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R7 during reset
    chk("R7 out_valid in reset", {127'b0, out_valid}, '0);
    chk("R7 in_ready in reset", {127'b0, in_ready}, {127'b0, 1'b1});
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 out_valid idle", {127'b0, out_valid}, '0);
    chk("R7 lane_vld idle", {124'b0, out_lane_vld}, '0);

    // R5 latency on an empty pipeline
    send("R5", 32'h0000_0003, 128'h4_0000_0003_0000_0002_0000_0001,
         128'h8_0000_0007_0000_0006_0000_0005, 4'hF);
    chk("R5 not after one edge", {127'b0, out_valid}, '0);
    @(negedge clk);
    chk("R5 valid after two edges", {127'b0, out_valid}, {127'b0, 1'b1});
    repeat (2) @(negedge clk);

    // R1 corner operands
    send("R1 lambda0", 32'h0, rnd_bus(), rnd_bus(), 4'hF);
    send("R1 lambda1", 32'h1, rnd_bus(), rnd_bus(), 4'hF);
    send("R1 allones", 32'hFFFF_FFFF, {BW{1'b1}}, {BW{1'b1}}, 4'hF);
    send("R1 allones w", 32'h8000_0000, '0, {BW{1'b1}}, 4'hF);
    // R3 distinct per-lane data under one lambda
    send("R3 lanes", 32'h1234_5678, 128'h0_FFFFFFFF_80000000_00000001,
         128'hDEADBEEF_00000001_80000000_FFFFFFFF, 4'hF);
    // R4 partial masks, tail groups
    send("R4 mask 0111", $urandom, rnd_bus(), rnd_bus(), 4'b0111);
    send("R4 mask 0001", $urandom, rnd_bus(), rnd_bus(), 4'b0001);
    send("R4 mask 1010", $urandom, rnd_bus(), rnd_bus(), 4'b1010);
    send("R4 mask 0000", $urandom, rnd_bus(), rnd_bus(), 4'b0000);
    repeat (4) @(negedge clk);

    // R6 hold downstream off, keep offering groups
    ready_mode = 2;
    @(negedge clk);
    fork
      begin
        for (int i = 0; i < 4; i++)
          send("R6 stall", $urandom, rnd_bus(), rnd_bus(), 4'hF);
      end
      begin
        repeat (8) @(negedge clk);
        chk("R6 in_ready while stalled", {127'b0, in_ready}, '0);
        ready_mode = 0;
      end
    join

    // R8 random stream under irregular back-pressure
    ready_mode = 1;
    for (int i = 0; i < 300; i++)
      send("R8 stream", $urandom, rnd_bus(), rnd_bus(), 4'($urandom));
    ready_mode = 0;
    repeat (10) @(negedge clk);
    chk("R8 queue drained", 128'(q_u.size()), '0);
    finish_run();
  end
endmodule